// File: doc/BRIEF.md
# Receive Telegram List Processor

This block files incoming receive telegrams into a shared 16-bit-wide memory. The memory holds linked chains of five-word receive headers. Each header names a telegram address, a storage mode, an expected arrival time, a length in data words and the location of the next header. When the deserializer announces a new telegram, the processor starts at the chain head chosen by `listSel` and follows the next-pointers until one of three things happens: a header claims the telegram, an end marker is reached, or a hop limit runs out.

Once a header claims the telegram, the processor checks the arrival time against the header's start time when that check is enabled. It then scatters each incoming data word into the header's data containers. The containers sit directly behind the header and are chained by size. Each container holds a length, a last-container flag and a start position within the telegram. Storage is a single buffer, a ping-pong pair of buffers, or a pass-through to a DMA word port. At the end of the telegram the header's valid/buffer bit and error flag are rewritten, and a saturating per-header error counter is bumped when the telegram was bad.

The memory is reached through one address with an asynchronous read path and a single write strobe. The processor issues at most one memory access per cycle.

Top module: `recvListProc`

## Requirements
- R1: After reset, and whenever `busy` is low, `ramWe` and `dmaValid` stay low.
- R2: A walk begins at the pointer held in memory word 0 (`listSel`=0) or word 1 (`listSel`=1). It follows header word 3 from header to header. A header word 0 with bits 15:14 both set is an end marker: the telegram is dropped and nothing is written.
- R3: Header word 0 holds the address in bits 7:0 and the address-check enable in bit 11. With bit 11 set, a header claims only an equal address. With bit 11 clear, it claims any address, and bits 7:0 are rewritten with the received address.
- R4: With the time-check enable (header word 0 bit 12) set, the telegram is in error when |`rxTime` − header word 1| exceeds `TIME_TOL` microseconds. A difference of exactly `TIME_TOL` is accepted.
- R5: The first container starts at header+5. Container word 0 holds the length in bits 9:0 and the last flag in bit 15, and word 1 holds the start position. In single-buffer mode (header bits 8 and 9 clear), telegram word k lands at container+2+(k−position). An error-free end sets header bit 10 and clears bit 13.
- R6: In double-buffer mode (bit 9 set, bit 8 clear), bit 10 names the valid buffer. Data goes to the other buffer: buffer 0 at container+2, buffer 1 at container+2+length. Bit 10 toggles only on an error-free end.
- R7: In DMA mode (bit 8 set), words in a container's range appear on `dmaData` with `dmaValid` in the cycle `rxWord` is high, and are not written to memory. The valid bit behaves as in single-buffer mode.
- R8: The next container follows at an offset equal to the current container's size: 2 in DMA mode, 2+length in single-buffer mode, 2+2·length in double-buffer mode. No container follows one with bit 15 set. Words before a container's position, and words after the last container, are dropped.
- R9: The telegram is bad if any of these holds: `rxErr` is high at `rxEnd`, a time error occurred, or the word count differs from header word 2. A bad telegram sets bit 13 and clears bit 10 in single-buffer and DMA modes, while in double-buffer mode bit 10 is left unchanged. It also increments header word 4, which saturates at 0xFFFF.
- R10: After `MAX_HOPS` headers without a claim or end marker, the telegram is dropped with no write.
- R11: `busy` rises the cycle after `rxStart`. In single-buffer and DMA modes, header bit 10 is cleared in memory before the first data word is filed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| listSel | input | 1 | Chain head to walk (memory word 0 or 1) |
| rxStart | input | 1 | Telegram start strobe |
| rxAddr | input | 8 | Received telegram address, valid with `rxStart` |
| rxTime | input | 16 | Arrival time in µs after master sync, valid with `rxStart` |
| rxWord | input | 1 | Data word strobe |
| rxData | input | 16 | Data word, valid with `rxWord` |
| rxEnd | input | 1 | Telegram end strobe |
| rxErr | input | 1 | Telegram corrupted, valid with `rxEnd` |
| ramAddr | output | AW | Memory word address |
| ramRdData | input | 16 | Memory read data, combinational from `ramAddr` |
| ramWe | output | 1 | Memory write strobe |
| ramWrData | output | 16 | Memory write data |
| dmaValid | output | 1 | DMA word strobe |
| dmaData | output | 16 | DMA word |
| busy | output | 1 | Processing a telegram |

## Verification
The checker relies on several input assumptions. The deserializer raises no `rxWord` or `rxEnd` while the chain is being walked. At least three quiet cycles separate consecutive word or end strobes, so that container words can be fetched between them. `rxStart` arrives only while the block is idle. The bench holds every telegram's first word back 50 cycles after `rxStart`, which exceeds the longest possible walk. It spaces strobes four cycles apart, and it starts the next telegram only after `busy` has fallen.

// File: rtl/recvPkg.sv
package recvPkg;
  localparam int DW = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_LIST, S_HDR0, S_NEXT, S_HDR1, S_HDR2, S_MARK,
    S_CW0, S_CW1, S_RECV, S_DROP, S_FIN0, S_FIN1
  } state_t;

  typedef enum logic [3:0] {
    AS_LIST, AS_H0, AS_H1, AS_H2, AS_H3, AS_H4, AS_C0, AS_C1, AS_BUF
  } addrSel_t;

  typedef struct packed {
    addrSel_t addrSel;
    logic     startTg;
    logic     ldPtr;
    logic     ldHdr;
    logic     ldTime;
    logic     ldLen;
    logic     wrMark;
    logic     firstCont;
    logic     ldCw0;
    logic     ldCw1;
    logic     stepCont;
    logic     takeWord;
    logic     takeEnd;
    logic     wrFin0;
    logic     wrFin1;
  } strobe_t;
endpackage

// File: rtl/recvListData.sv
module recvListData
  import recvPkg::*;
#(
  parameter int AW       = 11,
  parameter int TIME_TOL = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobe_t       stb,
  input  logic          listSel,
  input  logic [7:0]    rxAddr,
  input  logic [DW-1:0] rxTime,
  input  logic [DW-1:0] rxData,
  input  logic          rxErr,
  input  logic [DW-1:0] ramRdData,
  output logic [AW-1:0] ramAddr,
  output logic          ramWe,
  output logic [DW-1:0] ramWrData,
  output logic          dmaValid,
  output logic [DW-1:0] dmaData,
  output logic          isEnd,
  output logic          isMatch,
  output logic          wordLast,
  output logic          contLast
);
  logic [AW-1:0] ptr, cont, off, bufAddr, contSize;
  logic [DW-1:0] hdr, tlen, cPos, k, timeQ, dT, posEnd;
  logic [9:0]    cLen;
  logic [7:0]    addrQ;
  logic          cLast, timeErr, badQ, listQ;
  logic          dmaMode, dbufMode, vld, newV, inRange;
  logic [DW-1:0] markWord, finWord, cntWord;

  assign dmaMode  = hdr[8];
  assign dbufMode = hdr[9] & ~hdr[8];
  assign vld      = hdr[10];

  assign isEnd    = (ramRdData[15:14] == 2'b11);
  assign isMatch  = ~ramRdData[11] || (ramRdData[7:0] == addrQ);
  assign dT       = (timeQ >= ramRdData) ? timeQ - ramRdData : ramRdData - timeQ;
  assign posEnd   = cPos + DW'(cLen);
  assign inRange  = (k >= cPos) && (k < posEnd);
  assign wordLast = ((k + DW'(1)) == posEnd);
  assign contLast = cLast;

  assign off      = (dbufMode && !vld) ? AW'(cLen) : '0;
  assign bufAddr  = cont + AW'(2) + off + AW'(k - cPos);
  assign contSize = dmaMode  ? AW'(2) :
                    dbufMode ? AW'(2) + AW'({cLen, 1'b0}) : AW'(2) + AW'(cLen);

  always_comb begin
    unique case (stb.addrSel)
      AS_LIST: ramAddr = AW'(listQ);
      AS_H0:   ramAddr = ptr;
      AS_H1:   ramAddr = ptr + AW'(1);
      AS_H2:   ramAddr = ptr + AW'(2);
      AS_H3:   ramAddr = ptr + AW'(3);
      AS_H4:   ramAddr = ptr + AW'(4);
      AS_C0:   ramAddr = cont;
      AS_C1:   ramAddr = cont + AW'(1);
      default: ramAddr = bufAddr;
    endcase
  end

  assign newV     = badQ ? (dbufMode & vld) : (dbufMode ? ~vld : 1'b1);
  assign markWord = {hdr[15:11], dbufMode & vld, hdr[9:0]};
  assign finWord  = {hdr[15:14], badQ, hdr[12:11], newV, hdr[9:0]};
  assign cntWord  = (&ramRdData) ? ramRdData : ramRdData + DW'(1);

  assign dmaValid = stb.takeWord & inRange & dmaMode;
  assign dmaData  = rxData;

  always_comb begin
    ramWe     = 1'b0;
    ramWrData = markWord;
    if (stb.wrMark) begin
      ramWe = 1'b1;
    end else if (stb.takeWord && inRange && !dmaMode) begin
      ramWe = 1'b1;  ramWrData = rxData;
    end else if (stb.wrFin0) begin
      ramWe = 1'b1;  ramWrData = finWord;
    end else if (stb.wrFin1 && badQ) begin
      ramWe = 1'b1;  ramWrData = cntWord;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0; cont <= '0; hdr <= '0; tlen <= '0; cPos <= '0; k <= '0;
      timeQ <= '0; cLen <= '0; addrQ <= '0; cLast <= 1'b0;
      timeErr <= 1'b0; badQ <= 1'b0; listQ <= 1'b0;
    end else begin
      if (stb.startTg) begin
        addrQ <= rxAddr; timeQ <= rxTime; listQ <= listSel; k <= '0;
      end
      if (stb.ldPtr)     ptr     <= AW'(ramRdData);
      if (stb.ldHdr)     hdr     <= ramRdData[11] ? ramRdData : {ramRdData[15:8], addrQ};
      if (stb.ldTime)    timeErr <= hdr[12] && (dT > DW'(TIME_TOL));
      if (stb.ldLen)     tlen    <= ramRdData;
      if (stb.firstCont) cont    <= ptr + AW'(5);
      if (stb.ldCw0) begin
        cLen  <= ramRdData[9:0];
        cLast <= ramRdData[15];
      end
      if (stb.ldCw1)     cPos    <= ramRdData;
      if (stb.stepCont)  cont    <= cont + contSize;
      if (stb.takeWord)  k       <= k + DW'(1);
      if (stb.takeEnd)   badQ    <= rxErr | timeErr | (k != tlen);
    end
  end
endmodule

// File: rtl/recvListCtrl.sv
module recvListCtrl
  import recvPkg::*;
#(
  parameter int MAX_HOPS = 16
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    rxStart,
  input  logic    rxWord,
  input  logic    rxEnd,
  input  logic    isEnd,
  input  logic    isMatch,
  input  logic    wordLast,
  input  logic    contLast,
  output strobe_t stb,
  output logic    busy,
  output logic    walking
);
  localparam int HW = $clog2(MAX_HOPS + 1);

  state_t        st, nx;
  logic [HW-1:0] hops;

  assign busy    = (st != S_IDLE);
  assign walking = (st == S_LIST) || (st == S_HDR0) || (st == S_NEXT);

  always_comb begin
    nx          = st;
    stb         = '0;
    stb.addrSel = AS_LIST;
    unique case (st)
      S_IDLE: if (rxStart) begin stb.startTg = 1'b1; nx = S_LIST; end
      S_LIST: begin stb.ldPtr = 1'b1; nx = S_HDR0; end
      S_HDR0: begin
        stb.addrSel = AS_H0;
        if (isEnd) nx = S_DROP;
        else if (isMatch) begin stb.ldHdr = 1'b1; nx = S_HDR1; end
        else nx = S_NEXT;
      end
      S_NEXT: begin
        stb.addrSel = AS_H3;
        stb.ldPtr   = 1'b1;
        nx = (hops == HW'(MAX_HOPS - 1)) ? S_DROP : S_HDR0;
      end
      S_HDR1: begin stb.addrSel = AS_H1; stb.ldTime = 1'b1; nx = S_HDR2; end
      S_HDR2: begin stb.addrSel = AS_H2; stb.ldLen = 1'b1; nx = S_MARK; end
      S_MARK: begin
        stb.addrSel = AS_H0; stb.wrMark = 1'b1; stb.firstCont = 1'b1; nx = S_CW0;
      end
      S_CW0: begin stb.addrSel = AS_C0; stb.ldCw0 = 1'b1; nx = S_CW1; end
      S_CW1: begin stb.addrSel = AS_C1; stb.ldCw1 = 1'b1; nx = S_RECV; end
      S_RECV: begin
        stb.addrSel = AS_BUF;
        if (rxEnd) begin stb.takeEnd = 1'b1; nx = S_FIN0; end
        else if (rxWord) begin
          stb.takeWord = 1'b1;
          if (wordLast && !contLast) begin stb.stepCont = 1'b1; nx = S_CW0; end
        end
      end
      S_DROP: if (rxEnd) nx = S_IDLE;
      S_FIN0: begin stb.addrSel = AS_H0; stb.wrFin0 = 1'b1; nx = S_FIN1; end
      S_FIN1: begin stb.addrSel = AS_H4; stb.wrFin1 = 1'b1; nx = S_IDLE; end
      default: nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st   <= S_IDLE;
      hops <= '0;
    end else begin
      st <= nx;
      if (st == S_IDLE)      hops <= '0;
      else if (st == S_NEXT) hops <= hops + HW'(1);
    end
  end
endmodule

// File: rtl/recvListProc.sv
module recvListProc
  import recvPkg::*;
#(
  parameter int AW       = 11,
  parameter int TIME_TOL = 2,
  parameter int MAX_HOPS = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          listSel,
  input  logic          rxStart,
  input  logic [7:0]    rxAddr,
  input  logic [15:0]   rxTime,
  input  logic          rxWord,
  input  logic [15:0]   rxData,
  input  logic          rxEnd,
  input  logic          rxErr,
  output logic [AW-1:0] ramAddr,
  input  logic [15:0]   ramRdData,
  output logic          ramWe,
  output logic [15:0]   ramWrData,
  output logic          dmaValid,
  output logic [15:0]   dmaData,
  output logic          busy
);
  strobe_t stb;
  logic    isEnd, isMatch, wordLast, contLast, walking;

  recvListCtrl #(.MAX_HOPS(MAX_HOPS)) uCtrl (
    .clk(clk), .rstN(rstN), .rxStart(rxStart), .rxWord(rxWord), .rxEnd(rxEnd),
    .isEnd(isEnd), .isMatch(isMatch), .wordLast(wordLast), .contLast(contLast),
    .stb(stb), .busy(busy), .walking(walking)
  );

  recvListData #(.AW(AW), .TIME_TOL(TIME_TOL)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .listSel(listSel), .rxAddr(rxAddr),
    .rxTime(rxTime), .rxData(rxData), .rxErr(rxErr), .ramRdData(ramRdData),
    .ramAddr(ramAddr), .ramWe(ramWe), .ramWrData(ramWrData),
    .dmaValid(dmaValid), .dmaData(dmaData), .isEnd(isEnd), .isMatch(isMatch),
    .wordLast(wordLast), .contLast(contLast)
  );
endmodule

// File: rtl/recvListChk.sv
module recvListChk #(
  parameter int MAX_HOPS = 16
) (
  input logic clk,
  input logic rstN,
  input logic rxStart,
  input logic rxWord,
  input logic rxEnd,
  input logic busy,
  input logic walking,
  input logic ramWe,
  input logic dmaValid
);
  localparam int WALK_MAX = 2 * MAX_HOPS + 1;
  int unsigned walkCnt;

  always_ff @(posedge clk) begin
    if (!rstN)        walkCnt <= 0;
    else if (walking) walkCnt <= walkCnt + 1;
    else              walkCnt <= 0;
  end

  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!ramWe && !dmaValid)); // R1
  AST_WALK_NO_DATA: assert property (@(posedge clk) disable iff (!rstN)
    walking |-> (!rxWord && !rxEnd)); // R2
  AST_WALK_BOUNDED: assert property (@(posedge clk) disable iff (!rstN)
    walkCnt <= WALK_MAX); // R10
  AST_DMA_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    dmaValid |-> !ramWe); // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (rxStart && !busy) |=> busy); // R11
endmodule

bind recvListProc recvListChk #(.MAX_HOPS(MAX_HOPS)) uChk (
  .clk(clk), .rstN(rstN), .rxStart(rxStart), .rxWord(rxWord), .rxEnd(rxEnd),
  .busy(busy), .walking(walking), .ramWe(ramWe), .dmaValid(dmaValid)
);

// File: tb/tb_recvListProc.sv
module tb_recvListProc;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;

  logic clk = 1'b0, rstN = 1'b0;
  logic listSel = 1'b0, rxStart = 1'b0, rxWord = 1'b0, rxEnd = 1'b0, rxErr = 1'b0;
  logic [7:0]  rxAddr = '0;
  logic [15:0] rxTime = '0, rxData = '0;
  logic [AW-1:0] ramAddr;
  logic [15:0] ramRdData, ramWrData, dmaData;
  logic ramWe, dmaValid, busy;

  logic [15:0] mem [0:2047];
  logic [15:0] dmaLog [0:15];
  int dmaCnt = 0, weCnt = 0, nTest = 0, nFail = 0;
  logic [15:0] midSample;
  logic midBusy;

  always #(CLK_PERIOD/2) clk = ~clk;

  recvListProc #(.AW(AW), .TIME_TOL(2), .MAX_HOPS(16)) dut (
    .clk(clk), .rstN(rstN), .listSel(listSel), .rxStart(rxStart), .rxAddr(rxAddr),
    .rxTime(rxTime), .rxWord(rxWord), .rxData(rxData), .rxEnd(rxEnd), .rxErr(rxErr),
    .ramAddr(ramAddr), .ramRdData(ramRdData), .ramWe(ramWe), .ramWrData(ramWrData),
    .dmaValid(dmaValid), .dmaData(dmaData), .busy(busy)
  );

  assign ramRdData = mem[ramAddr];

  always @(posedge clk) begin
    if (ramWe) begin
      mem[ramAddr] <= ramWrData;
      weCnt <= weCnt + 1;
    end
    if (dmaValid) begin
      dmaLog[dmaCnt[3:0]] <= dmaData;
      dmaCnt <= dmaCnt + 1;
    end
  end

  function automatic logic [15:0] mk0(input logic [7:0] a, input logic dma, dbuf, val,
                                      achk, tchk, err);
    return {2'b00, err, tchk, achk, val, dbuf, dma, a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nTest++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setHdr(input int b, input logic [15:0] w0, t, len, nxt, cnt);
    mem[b] = w0; mem[b+1] = t; mem[b+2] = len; mem[b+3] = nxt; mem[b+4] = cnt;
  endtask

  task automatic setCont(input int b, input logic [9:0] len, input logic last,
                         input logic [15:0] pos);
    mem[b] = {last, 5'b0, len}; mem[b+1] = pos;
  endtask

  task automatic sendTg(input logic sel, input logic [7:0] a, input logic [15:0] t,
                        input int n, input logic [15:0] base, input logic err,
                        input int midAddr);
    @(negedge clk);
    listSel = sel; rxAddr = a; rxTime = t; rxStart = 1'b1;
    @(negedge clk);
    rxStart = 1'b0;
    repeat (50) @(negedge clk);
    if (midAddr >= 0) begin
      midSample = mem[midAddr];
      midBusy   = busy;
    end
    for (int i = 0; i < n; i++) begin
      rxData = base + 16'(i); rxWord = 1'b1;
      @(negedge clk);
      rxWord = 1'b0;
      repeat (3) @(negedge clk);
    end
    rxErr = err; rxEnd = 1'b1;
    @(negedge clk);
    rxEnd = 1'b0; rxErr = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("[TB] %0d tests run, %0d failed", nTest, nFail);
    $finish;
  end

  initial begin
    logic [15:0] cntA, base;
    logic v, e;
    int we0;
    for (int i = 0; i < 2048; i++) mem[i] = '0;
    mem[0] = 16'd16;
    mem[1] = 16'd230;
    setHdr(16,  mk0(5, 0, 0, 0, 1, 1, 0), 16'd100, 16'd3, 16'd40, 16'd0);
    setCont(21, 10'd3, 1'b1, 16'd0);
    setHdr(40,  mk0(7, 0, 1, 0, 1, 0, 0), 16'd300, 16'd4, 16'd80, 16'd0);
    setCont(45, 10'd2, 1'b0, 16'd0);
    setCont(51, 10'd2, 1'b1, 16'd2);
    setHdr(80,  mk0(9, 1, 0, 0, 1, 0, 0), 16'd500, 16'd2, 16'd90, 16'd0);
    setCont(85, 10'd2, 1'b1, 16'd0);
    mem[90] = 16'hC000;
    setHdr(230, mk0(3, 0, 0, 0, 1, 0, 0), 16'd0, 16'd4, 16'd200, 16'd0);
    setCont(235, 10'd2, 1'b0, 16'd1);
    setCont(239, 10'd1, 1'b1, 16'd3);
    setHdr(200, mk0(0, 0, 0, 0, 0, 0, 0), 16'd0, 16'd2, 16'd220, 16'd0);
    setCont(205, 10'd2, 1'b1, 16'd0);
    mem[220] = 16'hC000;
    setHdr(300, mk0(1, 0, 0, 0, 1, 0, 0), 16'd0, 16'd1, 16'd300, 16'd0);

    repeat (4) @(negedge clk);
    chk("R1 busy in reset", busy, 0);
    chk("R1 ramWe in reset", ramWe, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busy after reset", busy, 0);
    chk("R1 dmaValid after reset", dmaValid, 0);

    // R4 / R5 sweep of arrival time around the tolerance window
    cntA = 0;
    for (int off = -4; off <= 4; off++) begin
      base = 16'h1000 + 16'((off + 4) * 16);
      e = (off > 2) || (off < -2);
      sendTg(1'b0, 8'd5, 16'(100 + off), 3, base, 1'b0, -1);
      if (e) cntA = cntA + 16'd1;
      for (int j = 0; j < 3; j++) chk("R5 single buffer data", mem[23+j], base + 16'(j));
      chk("R4 time check header", mem[16], mk0(5, 0, 0, !e, 1, 1, e));
      chk("R9 counter after time sweep", mem[20], cntA);
    end
    sendTg(1'b0, 8'd5, 16'd100, 3, 16'h2000, 1'b0, -1);
    chk("R5 valid after good", mem[16], mk0(5, 0, 0, 1, 1, 1, 0));
    sendTg(1'b0, 8'd5, 16'd100, 3, 16'h2100, 1'b0, 16);
    chk("R11 valid cleared mid telegram", midSample[10], 0);
    chk("R11 busy mid telegram", midBusy, 1);
    chk("R5 valid restored", mem[16], mk0(5, 0, 0, 1, 1, 1, 0));

    // R9 corrupted telegram, then wrong length
    sendTg(1'b0, 8'd5, 16'd100, 3, 16'h2200, 1'b1, -1);
    cntA = cntA + 16'd1;
    chk("R9 rxErr header", mem[16], mk0(5, 0, 0, 0, 1, 1, 1));
    chk("R9 rxErr counter", mem[20], cntA);
    sendTg(1'b0, 8'd5, 16'd100, 2, 16'h2300, 1'b0, -1);
    cntA = cntA + 16'd1;
    chk("R9 length mismatch header", mem[16], mk0(5, 0, 0, 0, 1, 1, 1));
    chk("R9 length mismatch counter", mem[20], cntA);
    mem[20] = 16'hFFFF;
    sendTg(1'b0, 8'd5, 16'd100, 3, 16'h2400, 1'b1, -1);
    chk("R9 counter saturates", mem[20], 16'hFFFF);
    sendTg(1'b0, 8'd5, 16'd100, 3, 16'h2500, 1'b0, -1);
    chk("R9 good leaves counter", mem[20], 16'hFFFF);
    chk("R9 good clears flag", mem[16], mk0(5, 0, 0, 1, 1, 1, 0));

    // R6 / R8 double buffering over four telegrams, third one bad
    v = 1'b0;
    for (int it = 0; it < 4; it++) begin
      base = 16'h3000 + 16'(it * 16);
      e = (it == 2);
      sendTg(1'b0, 8'd7, 16'd300, 4, base, e, -1);
      chk("R6 buf c0 w0", mem[v ? 47 : 49], base);
      chk("R6 buf c0 w1", mem[v ? 48 : 50], base + 16'd1);
      chk("R8 buf c1 w0", mem[v ? 53 : 55], base + 16'd2);
      chk("R8 buf c1 w1", mem[v ? 54 : 56], base + 16'd3);
      if (!e) v = ~v;
      chk("R6 indicator", mem[40], mk0(7, 0, 1, v, 1, 0, e));
    end

    // R7 DMA pass-through
    dmaCnt = 0; we0 = weCnt;
    sendTg(1'b0, 8'd9, 16'd500, 2, 16'h4000, 1'b0, -1);
    chk("R7 dma count", dmaCnt, 2);
    chk("R7 dma word0", dmaLog[0], 16'h4000);
    chk("R7 dma word1", dmaLog[1], 16'h4001);
    chk("R7 only header writes", weCnt - we0, 2);
    chk("R7 valid set", mem[80], mk0(9, 1, 0, 1, 1, 0, 0));

    // R2 end marker drops unknown address
    we0 = weCnt;
    sendTg(1'b0, 8'd33, 16'd0, 2, 16'h4100, 1'b0, -1);
    chk("R2 no write on end marker", weCnt - we0, 0);
    chk("R2 idle after drop", busy, 0);

    // R3 address check off on second chain
    sendTg(1'b1, 8'd77, 16'd0, 2, 16'h5000, 1'b0, -1);
    chk("R3 address stored", mem[200], mk0(77, 0, 0, 1, 0, 0, 0));
    chk("R3 data w0", mem[207], 16'h5000);
    chk("R3 data w1", mem[208], 16'h5001);

    // R8 position gap and container chaining
    sendTg(1'b1, 8'd3, 16'd0, 4, 16'h6000, 1'b0, -1);
    chk("R8 pos gap c0 w0", mem[237], 16'h6001);
    chk("R8 pos gap c0 w1", mem[238], 16'h6002);
    chk("R8 second container", mem[241], 16'h6003);
    chk("R8 c1 pos untouched", mem[240], 16'd3);
    chk("R8 header good", mem[230], mk0(3, 0, 0, 1, 1, 0, 0));

    // R10 looping chain hits hop limit
    mem[1] = 16'd300;
    we0 = weCnt;
    sendTg(1'b1, 8'd2, 16'd0, 1, 16'h7000, 1'b0, -1);
    chk("R10 no write on hop limit", weCnt - we0, 0);
    chk("R10 idle after hop limit", busy, 0);
    mem[1] = 16'd230;

    $display("[TB] %0d tests run, %0d failed", nTest, nFail);
    $finish;
  end
endmodule